// File: doc/BRIEF.md
# Write-to-Bus Burst Splitter

This block sits behind the receive FIFO of a PCI-style target and turns each buffered write word into AHB master write operations. Every FIFO word carries a 32-bit data word, four byte enables, a 3-bit window number, a word address and a last-word flag. The window number selects one of three paths. Windows 0 to 3 are memory windows that may form incrementing word bursts. Window 4 is the register path, served through a request/grant handshake. Window 5 is an I/O window that issues only single transfers. Windows 6 and 7 are discarded.

For memory windows the AHB address is rebuilt from an 8-bit base byte per window, which supplies the top address byte, and the word address bits [23:2]. For byte writes, address bits [1:0] carry the lane number. Memory windows are meant to map onto plain memory only. I/O space and queue-manager space are reached through the single-only I/O window, which passes address bits [31:2] through unchanged. The transfer size is chosen per word from its byte enables. A write can therefore mix incrementing word bursts with runs of individual byte writes.

The control is one state machine with four states:
- `ST_IDLE` decodes the FIFO head word.
- `ST_ADDR` holds an address phase.
- `ST_DATA` holds the matching data phase.
- `ST_CSR` holds the register request.

The transitions are:
- `ST_IDLE`→`ST_CSR` on a window-4 word.
- `ST_IDLE`→`ST_ADDR` on a memory or I/O word with at least one enable.
- `ST_IDLE`→`ST_IDLE` with a pop on a discarded word.
- `ST_ADDR`→`ST_DATA` when `hready` is high.
- `ST_DATA`→`ST_ADDR` when `hready` is high and byte lanes remain.
- `ST_DATA`→`ST_IDLE` with a pop when `hready` is high and the word is finished.
- `ST_CSR`→`ST_IDLE` with a pop when `csr_gnt` is high.

Beats never overlap. While an incrementing burst is held open between words, the idle slots carry BUSY with the next beat's address.

Top module: `pci_wr_splitter`

## Requirements
- R1: After reset `htrans` is IDLE (2'b00), `hwrite` is 0, `rx_pop` is 0 and `csr_req` is 0.
- R2: A window-4 word raises `csr_req` and holds it until `csr_gnt`. In the grant cycle `csr_addr`, `csr_wdata` and `csr_be` equal the word's address, data and enables, and the word is popped. No AHB transfer is issued for that word, and `htrans` stays IDLE while `csr_req` is high.
- R3: A memory-window word with all enables set (4'hF) issues one word beat with `hsize` 3'b010 and `hburst` INCR (3'b001). The first beat of a burst has `htrans` NONSEQ (2'b10). A beat that continues an open burst has SEQ (2'b11), and its address is the previous beat plus 4. A burst stays open after a full word without the last flag. It closes on the last flag or on any word that is not a full memory word.
- R4: The memory-window AHB address is {base byte n, word address [23:2], lane}, where base byte n is `mem_base[8n+7:8n]` for window n.
- R5: A memory or I/O word whose enables are neither all set nor all clear issues one byte write per enabled lane, lane 0 first. Each byte write has `hsize` 3'b000, `hburst` SINGLE (3'b000), `htrans` NONSEQ and address bits [1:0] equal to the lane.
- R6: The byte writes of a partial word that follows an open burst start with NONSEQ, and the next full word starts a new burst with NONSEQ.
- R7: A window-5 word with all enables set issues one NONSEQ SINGLE word write at {word address [31:2], 2'b00}. A partial window-5 word follows R5. Window 5 never produces SEQ.
- R8: A memory or I/O word with no enables set, and any window-6 or window-7 word, is popped with no AHB or register transfer.
- R9: While `hready` is low, an address phase holds `haddr`, `htrans` and `hsize` stable. An AHB word is popped exactly in the cycle its last data phase completes with `hready` high.
- R10: During each data phase `hwdata` equals the data of the word being written.
- R11: A full memory word whose translated address is not the previous beat plus 4 starts a new burst with NONSEQ, even while a burst is open.
- R12: AHB writes use only SINGLE and INCR burst types, and `hwrite` is high for every NONSEQ or SEQ beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | FIFO head word is present |
| rx_data | input | 32 | Head word data |
| rx_be | input | 4 | Head word byte enables, bit n for lane n |
| rx_addr | input | 32 | Head word PCI address |
| rx_win | input | 3 | Head word window number |
| rx_last | input | 1 | Head word is the last of its transfer |
| rx_pop | output | 1 | Removes the head word at this edge |
| mem_base | input | 32 | Base bytes of memory windows 0 to 3, window n in bits [8n+7:8n] |
| csr_req | output | 1 | Register write request |
| csr_gnt | input | 1 | Register write grant; the write happens in this cycle |
| csr_addr | output | 32 | Register write address |
| csr_wdata | output | 32 | Register write data |
| csr_be | output | 4 | Register write byte enables |
| haddr | output | 32 | AHB address |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB write strobe |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type |
| hwdata | output | 32 | AHB write data |
| hready | input | 1 | AHB ready |

## Verification
The bench targets these corner cases:
- Burst continuation across FIFO words, including a break caused by a partial word, a register word, a zero-enable word or a non-contiguous address. A design that kept the burst open would emit SEQ where NONSEQ is due.
- Byte-lane ordering and lane addressing. A wrong lane picker would issue the byte writes out of order or at the wrong addresses.
- Pop timing under random `hready` stalls. Popping early would hand the next word's data to a pending data phase, and an unstable address phase would be caught in the stall cycles.
- Discarded and register words. A transfer leaking onto AHB for either kind of word shows up as an unexpected beat.

// File: rtl/pws_pkg.sv
package pws_pkg;
    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] SZ_BYTE   = 3'b000;
    localparam logic [2:0] SZ_WORD   = 3'b010;

    localparam logic [2:0] BU_SINGLE = 3'b000;
    localparam logic [2:0] BU_INCR   = 3'b001;

    typedef enum logic [1:0] {
        PATH_MEM,
        PATH_CSR,
        PATH_IO,
        PATH_DROP
    } path_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_CSR
    } state_t;
endpackage

// File: rtl/pws_decode.sv
module pws_decode
    import pws_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LANES   = 4,
    parameter int WIN_W   = 3,
    parameter int NUM_MEM = 4,
    parameter int BASE_W  = 8,
    parameter int CSR_ID  = 4,
    parameter int IO_ID   = 5
) (
    input  logic [WIN_W-1:0]          win,
    input  logic [LANES-1:0]          be,
    input  logic [AW-1:$clog2(LANES)] waddr,
    input  logic [NUM_MEM*BASE_W-1:0] bases,
    output path_t                     path,
    output logic                      full,
    output logic [AW-1:0]             xaddr
);
    localparam int LB = $clog2(LANES);

    logic [NUM_MEM-1:0]  win_hit;
    logic [BASE_W-1:0]   base_sel;
    path_t               raw_path;

    // one comparator per memory window
    genvar g;
    generate
        for (g = 0; g < NUM_MEM; g++) begin : g_hit
            assign win_hit[g] = (win == WIN_W'(g));
        end
    endgenerate

    always_comb begin
        base_sel = '0;
        for (int i = 0; i < NUM_MEM; i++) begin
            if (win_hit[i]) begin
                base_sel = bases[i*BASE_W +: BASE_W];
            end
        end
    end

    always_comb begin
        full  = &be;
        xaddr = {waddr, {LB{1'b0}}};
        if (|win_hit) begin
            raw_path = PATH_MEM;
            xaddr    = {base_sel, waddr[AW-BASE_W-1:LB], {LB{1'b0}}};
        end else if (win == WIN_W'(CSR_ID)) begin
            raw_path = PATH_CSR;
        end else if (win == WIN_W'(IO_ID)) begin
            raw_path = PATH_IO;
        end else begin
            raw_path = PATH_DROP;
        end
        path = raw_path;
        if ((raw_path == PATH_MEM || raw_path == PATH_IO) && be == '0) begin
            path = PATH_DROP;
        end
    end
endmodule

// File: rtl/pws_lane_pick.sv
module pws_lane_pick #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0]         mask,
    output logic [$clog2(LANES)-1:0] idx,
    output logic [LANES-1:0]         rest
);
    localparam int IW = $clog2(LANES);

    // lowest set lane wins; rest is the mask with that lane removed
    always_comb begin
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IW'(i);
            end
        end
        rest = mask & (mask - LANES'(1));
    end
endmodule

// File: rtl/pci_wr_splitter.sv
module pci_wr_splitter
    import pws_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int WIN_W   = 3,
    parameter int NUM_MEM = 4,
    parameter int BASE_W  = 8,
    parameter int CSR_ID  = 4,
    parameter int IO_ID   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_valid,
    input  logic [DW-1:0]             rx_data,
    input  logic [DW/8-1:0]           rx_be,
    input  logic [AW-1:0]             rx_addr,
    input  logic [WIN_W-1:0]          rx_win,
    input  logic                      rx_last,
    output logic                      rx_pop,
    input  logic [NUM_MEM*BASE_W-1:0] mem_base,
    output logic                      csr_req,
    input  logic                      csr_gnt,
    output logic [AW-1:0]             csr_addr,
    output logic [DW-1:0]             csr_wdata,
    output logic [DW/8-1:0]           csr_be,
    output logic [AW-1:0]             haddr,
    output logic [1:0]                htrans,
    output logic                      hwrite,
    output logic [2:0]                hsize,
    output logic [2:0]                hburst,
    output logic [DW-1:0]             hwdata,
    input  logic                      hready
);
    localparam int LANES = DW / 8;
    localparam int LB    = $clog2(LANES);
    localparam logic [AW-1:0] BEAT_STEP = AW'(LANES);

    state_t            state_q;
    logic [DW-1:0]     cur_data_q;
    logic [LANES-1:0]  cur_be_q;
    logic [AW-1:0]     cur_addr_q;
    logic              cur_last_q;
    logic [AW-1:0]     beat_addr_q;
    logic [LANES-1:0]  lanes_q;
    logic              beat_word_q;
    logic              beat_incr_q;
    logic              beat_seq_q;
    logic              burst_open_q;

    path_t             dec_path;
    logic              dec_full;
    logic [AW-1:0]     dec_addr;
    logic [LB-1:0]     head_lane;
    logic [LANES-1:0]  head_rest;
    logic [LB-1:0]     next_lane;
    logic [LANES-1:0]  next_rest;
    logic              contig;

    pws_decode #(
        .AW(AW), .LANES(LANES), .WIN_W(WIN_W), .NUM_MEM(NUM_MEM),
        .BASE_W(BASE_W), .CSR_ID(CSR_ID), .IO_ID(IO_ID)
    ) u_dec (
        .win   (rx_win),
        .be    (rx_be),
        .waddr (rx_addr[AW-1:LB]),
        .bases (mem_base),
        .path  (dec_path),
        .full  (dec_full),
        .xaddr (dec_addr)
    );

    pws_lane_pick #(.LANES(LANES)) u_pick_head (
        .mask (rx_be),
        .idx  (head_lane),
        .rest (head_rest)
    );

    pws_lane_pick #(.LANES(LANES)) u_pick_next (
        .mask (lanes_q),
        .idx  (next_lane),
        .rest (next_rest)
    );

    assign contig = (dec_addr == beat_addr_q + BEAT_STEP);

    // state register and beat bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cur_data_q   <= '0;
            cur_be_q     <= '0;
            cur_addr_q   <= '0;
            cur_last_q   <= 1'b0;
            beat_addr_q  <= '0;
            lanes_q      <= '0;
            beat_word_q  <= 1'b0;
            beat_incr_q  <= 1'b0;
            beat_seq_q   <= 1'b0;
            burst_open_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rx_valid) begin
                        unique case (dec_path)
                            PATH_DROP: begin
                                burst_open_q <= 1'b0;
                            end
                            PATH_CSR: begin
                                cur_data_q   <= rx_data;
                                cur_be_q     <= rx_be;
                                cur_addr_q   <= rx_addr;
                                burst_open_q <= 1'b0;
                                state_q      <= ST_CSR;
                            end
                            PATH_MEM, PATH_IO: begin
                                cur_data_q <= rx_data;
                                cur_last_q <= rx_last;
                                state_q    <= ST_ADDR;
                                if (dec_full) begin
                                    beat_word_q <= 1'b1;
                                    beat_incr_q <= (dec_path == PATH_MEM);
                                    beat_seq_q  <= (dec_path == PATH_MEM) && burst_open_q && contig;
                                    beat_addr_q <= dec_addr;
                                    lanes_q     <= '0;
                                end else begin
                                    beat_word_q <= 1'b0;
                                    beat_incr_q <= 1'b0;
                                    beat_seq_q  <= 1'b0;
                                    beat_addr_q <= {dec_addr[AW-1:LB], head_lane};
                                    lanes_q     <= head_rest;
                                end
                                if (dec_path == PATH_IO || !dec_full) begin
                                    burst_open_q <= 1'b0;
                                end
                            end
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (hready) begin
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (hready) begin
                        if (lanes_q != '0) begin
                            beat_addr_q <= {beat_addr_q[AW-1:LB], next_lane};
                            lanes_q     <= next_rest;
                            state_q     <= ST_ADDR;
                        end else begin
                            burst_open_q <= beat_incr_q && !cur_last_q;
                            state_q      <= ST_IDLE;
                        end
                    end
                end
                ST_CSR: begin
                    if (csr_gnt) begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        htrans = TR_IDLE;
        hwdata = '0;
        rx_pop = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                htrans = burst_open_q ? TR_BUSY : TR_IDLE;
                rx_pop = rx_valid && (dec_path == PATH_DROP);
            end
            ST_ADDR: begin
                htrans = beat_seq_q ? TR_SEQ : TR_NONSEQ;
            end
            ST_DATA: begin
                htrans = (beat_incr_q && !cur_last_q) ? TR_BUSY : TR_IDLE;
                hwdata = cur_data_q;
                rx_pop = hready && (lanes_q == '0);
            end
            ST_CSR: begin
                rx_pop = csr_gnt;
            end
        endcase
        haddr     = (htrans == TR_BUSY) ? beat_addr_q + BEAT_STEP : beat_addr_q;
        hwrite    = (htrans != TR_IDLE);
        hsize     = beat_word_q ? SZ_WORD : SZ_BYTE;
        hburst    = beat_incr_q ? BU_INCR : BU_SINGLE;
        csr_req   = (state_q == ST_CSR);
        csr_addr  = cur_addr_q;
        csr_wdata = cur_data_q;
        csr_be    = cur_be_q;
    end

    // R9: a pop is only issued against a present head word
    a_r9_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> rx_valid);

    // R9: a stalled address phase keeps its address, type and size
    a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        ((htrans == TR_NONSEQ || htrans == TR_SEQ) && !hready)
        |=> ($stable(haddr) && $stable(htrans) && $stable(hsize)));

    // R3: a SEQ beat only ever follows BUSY or a stalled SEQ
    a_r3_seq_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_SEQ) |-> ($past(htrans) == TR_BUSY || $past(htrans) == TR_SEQ));

    // R5: byte-size beats are always fresh SINGLE transfers
    a_r5_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
        ((htrans == TR_NONSEQ || htrans == TR_SEQ) && hsize == SZ_BYTE)
        |-> (hburst == BU_SINGLE && htrans == TR_NONSEQ));

    // R2: the register request is held until granted, with steady fields
    a_r2_csr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_gnt) |=> (csr_req && $stable(csr_addr) && $stable(csr_wdata)));

    // R2: no bus activity while a register write is pending
    a_r2_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        csr_req |-> (htrans == TR_IDLE));
endmodule

// File: tb/sim_pci_wr_splitter.sv
module sim_pci_wr_splitter;
    import pws_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid;
    logic [31:0] rx_data;
    logic [3:0]  rx_be;
    logic [31:0] rx_addr;
    logic [2:0]  rx_win;
    logic        rx_last;
    logic        rx_pop;
    logic [31:0] mem_base;
    logic        csr_req;
    logic        csr_gnt;
    logic [31:0] csr_addr;
    logic [31:0] csr_wdata;
    logic [3:0]  csr_be;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [2:0]  hsize;
    logic [2:0]  hburst;
    logic [31:0] hwdata;
    logic        hready;

    always #5 clk = ~clk;

    pci_wr_splitter u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_be(rx_be), .rx_addr(rx_addr), .rx_win(rx_win), .rx_last(rx_last),
        .rx_pop(rx_pop), .mem_base(mem_base), .csr_req(csr_req), .csr_gnt(csr_gnt),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_be(csr_be),
        .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
        .hburst(hburst), .hwdata(hwdata), .hready(hready)
    );

    typedef struct {
        logic [31:0] data;
        logic [3:0]  be;
        logic [31:0] addr;
        logic [2:0]  win;
        bit          last;
        int          kind;   // 0 bus, 1 register, 2 discarded
        int          id;
    } word_t;

    typedef struct {
        logic [31:0] addr;
        logic [1:0]  trans;
        logic [2:0]  size;
        logic [2:0]  burst;
        logic [31:0] data;
        bit          fin;
        int          id;
    } beat_t;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } reg_t;

    word_t src_q[$];
    beat_t exp_q[$];
    reg_t  reg_q[$];

    int    n_chk = 0;
    int    n_fail = 0;
    int    next_id = 0;
    bit    m_open = 1'b0;
    logic [31:0] m_last = '0;
    bit    stall_on = 1'b0;
    bit    done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference model: derive expected bus beats and register writes from one word
    task automatic push(input logic [2:0] win, input logic [31:0] addr,
                        input logic [3:0] be, input logic [31:0] data, input bit last);
        word_t w;
        beat_t b;
        reg_t  r;
        logic [31:0] xa;
        w.data = data; w.be = be; w.addr = addr; w.win = win; w.last = last;
        w.id = next_id; next_id++;
        if (win == 3'd4) begin
            w.kind = 1;
            r.addr = addr; r.data = data; r.be = be;
            reg_q.push_back(r);
            m_open = 1'b0;
        end else if (win > 3'd5 || be == 4'h0) begin
            w.kind = 2;
            m_open = 1'b0;
        end else begin
            w.kind = 0;
            if (win < 3'd4) xa = {mem_base[int'(win)*8 +: 8], addr[23:2], 2'b00};
            else            xa = {addr[31:2], 2'b00};
            b.data = data; b.id = w.id;
            if (win < 3'd4 && be == 4'hF) begin
                b.trans = (m_open && xa == m_last + 32'd4) ? TR_SEQ : TR_NONSEQ;
                b.size = SZ_WORD; b.burst = BU_INCR; b.addr = xa; b.fin = 1'b1;
                exp_q.push_back(b);
                m_open = !last;
                m_last = xa;
            end else if (be == 4'hF) begin
                b.trans = TR_NONSEQ; b.size = SZ_WORD; b.burst = BU_SINGLE;
                b.addr = xa; b.fin = 1'b1;
                exp_q.push_back(b);
                m_open = 1'b0;
            end else begin
                for (int l = 0; l < 4; l++) begin
                    if (be[l]) begin
                        b.trans = TR_NONSEQ; b.size = SZ_BYTE; b.burst = BU_SINGLE;
                        b.addr = xa | 32'(l);
                        b.fin = ((be >> (l + 1)) == 4'h0);
                        exp_q.push_back(b);
                    end
                end
                m_open = 1'b0;
            end
        end
        src_q.push_back(w);
    endtask

    // FIFO head and handshake inputs, driven just after each rising edge
    initial begin
        rx_valid = 0; rx_data = '0; rx_be = '0; rx_addr = '0; rx_win = '0; rx_last = 0;
        hready = 1'b1; csr_gnt = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (src_q.size() > 0) begin
                rx_valid = 1'b1;
                rx_data = src_q[0].data; rx_be = src_q[0].be; rx_addr = src_q[0].addr;
                rx_win = src_q[0].win; rx_last = src_q[0].last;
            end else begin
                rx_valid = 1'b0;
                rx_data = '0; rx_be = '0; rx_addr = '0; rx_win = '0; rx_last = 1'b0;
            end
            hready  = stall_on ? (lfsr[0] | lfsr[3]) : 1'b1;
            csr_gnt = stall_on ? lfsr[5] : 1'b1;
        end
    end

    // monitor, compared on every falling edge
    beat_t dp;
    bit    dp_pend = 1'b0;
    bit    prev_stall = 1'b0;
    logic [31:0] prev_addr;
    logic [1:0]  prev_trans;
    logic [2:0]  prev_size;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                bit    dp_done;
                word_t hd;
                beat_t e;
                reg_t  r;
                string t;
                if (prev_stall) begin
                    check(haddr == prev_addr && htrans == prev_trans && hsize == prev_size,
                          "R9", "stalled address phase changed", haddr, prev_addr);
                end
                dp_done = dp_pend && hready;
                if (dp_done) begin
                    check(hwdata == dp.data, "R10", "hwdata", hwdata, dp.data);
                end
                if (dp_done && dp.fin && !rx_pop) begin
                    check(1'b0, "R9", "no pop at last data phase", 32'(rx_pop), 32'd1);
                end
                if (csr_req && csr_gnt && !rx_pop) begin
                    check(1'b0, "R2", "no pop at grant", 32'(rx_pop), 32'd1);
                end
                if (rx_pop) begin
                    if (src_q.size() == 0) begin
                        check(1'b0, "R9", "pop with empty source", 32'd1, 32'd0);
                    end else begin
                        hd = src_q.pop_front();
                        if (hd.kind == 0)
                            check(dp_done && dp.fin && dp.id == hd.id, "R9",
                                  "pop of bus word off its last data phase", 32'(dp_done), 32'd1);
                        else if (hd.kind == 1)
                            check(csr_req && csr_gnt, "R2", "register pop without grant",
                                  32'(csr_req && csr_gnt), 32'd1);
                        else
                            check(!dp_pend && !csr_req, "R8", "discarded word pop",
                                  32'(dp_pend), 32'd0);
                    end
                end
                if (dp_done) dp_pend = 1'b0;
                if ((htrans == TR_NONSEQ || htrans == TR_SEQ) && hready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected bus beat", haddr, 32'd0);
                    end else begin
                        e = exp_q.pop_front();
                        t = (e.size == SZ_BYTE) ? "R5" : ((e.burst == BU_INCR) ? "R3" : "R7");
                        check(haddr == e.addr, "R4", {t, " beat address"}, haddr, e.addr);
                        check(htrans == e.trans, t, "beat htrans (R6/R11)", 32'(htrans), 32'(e.trans));
                        check(hsize == e.size, t, "beat hsize", 32'(hsize), 32'(e.size));
                        check(hburst == e.burst && hwrite, "R12", "beat hburst/hwrite",
                              32'({hwrite, hburst}), 32'({1'b1, e.burst}));
                        dp = e;
                        dp_pend = 1'b1;
                    end
                end
                if (csr_req && csr_gnt) begin
                    if (reg_q.size() == 0) begin
                        check(1'b0, "R2", "unexpected register write", csr_addr, 32'd0);
                    end else begin
                        r = reg_q.pop_front();
                        check(csr_addr == r.addr, "R2", "register address", csr_addr, r.addr);
                        check(csr_wdata == r.data, "R2", "register data", csr_wdata, r.data);
                        check(csr_be == r.be, "R2", "register enables", 32'(csr_be), 32'(r.be));
                    end
                end
                prev_stall = (htrans == TR_NONSEQ || htrans == TR_SEQ) && !hready;
                prev_addr  = haddr;
                prev_trans = htrans;
                prev_size  = hsize;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic drain();
        int cyc = 0;
        while ((src_q.size() > 0 || exp_q.size() > 0 || reg_q.size() > 0 || dp_pend)
               && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        check(src_q.size() == 0 && exp_q.size() == 0 && reg_q.size() == 0, "R9",
              "drain incomplete", 32'(src_q.size()), 32'd0);
        repeat (3) @(posedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        mem_base = 32'hC3A25110;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(htrans == TR_IDLE, "R1", "htrans after reset", 32'(htrans), 32'd0);
        check(!hwrite && !rx_pop && !csr_req, "R1", "hwrite/pop/req after reset",
              32'({hwrite, rx_pop, csr_req}), 32'd0);
        @(posedge clk); #2;

        // R3 R4: four-beat burst in window 1
        for (int i = 0; i < 4; i++)
            push(3'd1, 32'h0000_1000 + 32'(4*i), 4'hF, 32'hA000_0000 + 32'(i), i == 3);
        drain();
        // R6: burst broken by a partial word, then a fresh burst
        push(3'd0, 32'h0000_2000, 4'hF, 32'h1111_0000, 1'b0);
        push(3'd0, 32'h0000_2004, 4'hF, 32'h1111_0001, 1'b0);
        push(3'd0, 32'h0000_2008, 4'b0101, 32'h1111_0002, 1'b0);
        push(3'd0, 32'h0000_200C, 4'hF, 32'h1111_0003, 1'b1);
        drain();
        // R5: byte lanes in ascending order
        push(3'd2, 32'h00AB_CDE0, 4'b1000, 32'h2222_2222, 1'b0);
        push(3'd2, 32'h00AB_CDE4, 4'b0110, 32'h3333_3333, 1'b1);
        // R7 R8: I/O window full, partial and empty words
        push(3'd5, 32'h8000_0040, 4'hF, 32'h4444_0000, 1'b0);
        push(3'd5, 32'h8000_0044, 4'b1010, 32'h4444_0001, 1'b0);
        push(3'd5, 32'h8000_0048, 4'h0, 32'h4444_0002, 1'b1);
        drain();
        // R2: register word splits an open burst
        push(3'd3, 32'h0000_3000, 4'hF, 32'h5555_0000, 1'b0);
        push(3'd4, 32'h0000_00A8, 4'b0011, 32'h5555_0001, 1'b0);
        push(3'd3, 32'h0000_3004, 4'hF, 32'h5555_0002, 1'b1);
        // R8: discarded windows and an empty memory word
        push(3'd6, 32'h0000_4000, 4'hF, 32'h6666_0000, 1'b0);
        push(3'd7, 32'h0000_4004, 4'hF, 32'h6666_0001, 1'b0);
        push(3'd3, 32'h0000_4008, 4'h0, 32'h6666_0002, 1'b1);
        // R11: non-contiguous full words
        push(3'd3, 32'h0000_5000, 4'hF, 32'h7777_0000, 1'b0);
        push(3'd3, 32'h0000_5008, 4'hF, 32'h7777_0001, 1'b1);
        drain();

        // random stream under stalls and slow grants
        stall_on = 1'b1;
        begin
            logic [31:0] a;
            logic [2:0]  w;
            logic [3:0]  be;
            a = 32'h0012_3400;
            w = 3'd0;
            for (int i = 0; i < 300; i++) begin
                if ($urandom_range(0, 5) == 0) w = 3'($urandom_range(0, 7));
                be = ($urandom_range(0, 1) == 1) ? 4'hF : 4'($urandom_range(0, 15));
                if ($urandom_range(0, 9) == 0) a = a + 32'h8;
                else a = a + 32'h4;
                push(w, a, be, $urandom, $urandom_range(0, 5) == 0);
                if ((i % 40) == 39) drain();
            end
        end
        drain();
        finish_run();
    end
endmodule